// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block decides when a processor-style bus master hands its local bus to an external requester, such as a DMA engine. The requester raises an asynchronous hold request. The block watches the phase of the bus cycle in progress and three status qualifiers from the cycle generator. From these it decides the clock edge at which the master lets go of the bus. It then raises a hold-acknowledge toward the requester and a float-enable that turns the multiplexed address/data drivers to high impedance.

The block never interrupts a cycle midway. A request seen during an active cycle is honoured only at the final phase of that cycle. It also requires the request to have been visible by the second phase. A handover is refused when the cycle is the low-byte half of a two-cycle word access, or the first cycle of an interrupt-acknowledge pair. It is also refused for as long as a locked instruction runs. On an idle bus the handover is immediate.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After a synchronous reset, `hold_ack` and `bus_float` are both 0.
- R2: `hold_req` passes through a two-flop synchronizer. A request raised before clock edge k cannot raise `hold_ack` before edge k+2. On an idle bus with lock clear, `hold_ack` rises at edge k+2.
- R3: `cycle_phase` uses these codes: 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4. While the phase is idle (0), a synchronized request with lock clear raises `hold_ack` at the next clock edge.
- R4: A synchronized request seen during T1 or T2 of an active cycle, and held since, raises `hold_ack` at the edge that ends T4 of that cycle, not earlier.
- R5: A request first seen synchronized during T3 or Tw is not granted at the T4 of that cycle. It is granted at the T4 of the next unblocked cycle.
- R6: No grant is made at a T4 where `low_byte_half` is 1; the request stays pending.
- R7: No grant is made at a T4 where `inta_first` is 1; the request stays pending.
- R8: While `lock_active` is 1, `hold_ack` does not rise in any phase, idle included.
- R9: Once granted, `hold_ack` falls at the first clock edge at which the synchronized request is 0.
- R10: `bus_float` is 1 whenever `hold_ack` is 1. It stays 1 for exactly one clock after `hold_ack` falls, unless a new grant follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| cycle_phase | input | 3 | Current bus-cycle phase code (0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4) |
| low_byte_half | input | 1 | Current cycle is the low-byte half of a split word access |
| inta_first | input | 1 | Current cycle is the first of an interrupt-acknowledge pair |
| lock_active | input | 1 | A locked instruction is executing |
| hold_ack | output | 1 | Registered hold acknowledge to the requester |
| bus_float | output | 1 | Registered float-enable for the address/data drivers |

## Verification
The bench builds the block with its default `SYNC_STAGES` of 2 and `PHASE_W` of 3, the widths the phase codes and the reference model assume. With two stages, a request raised in the final idle clock before T1 becomes visible exactly at T2. A request raised at T2 becomes visible only at Tw. This brings both the on-time path and the deferred path of the deadline into reach with single-clock stimulus shifts. Cycles with wait states, split-word and acknowledge qualifiers, lock held over idle, and a one-clock request pulse are compared against the model on every clock.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } bus_phase_e;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q[s] <= 1'b0;
        end else begin
          chain_q[s] <= (s == 0) ? async_in : chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      // R2
      sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(async_in, 2));
    end
  endgenerate
endmodule

// File: rtl/cycle_eligibility.sv
module cycle_eligibility
  import bus_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_s,
  input  bus_phase_e phase,
  input  logic       low_byte_half,
  input  logic       inta_first,
  input  logic       lock_active,
  output logic       handover_ok
);
  logic armed_q;
  logic early_phase;
  logic end_ok;

  assign early_phase = (phase == PH_T1) || (phase == PH_T2);

  always_ff @(posedge clk) begin
    if (rst || !req_s || phase == PH_T4) begin
      armed_q <= 1'b0;
    end else if (early_phase) begin
      armed_q <= 1'b1;
    end
  end

  assign end_ok = (phase == PH_T4) && armed_q && !low_byte_half && !inta_first;

  assign handover_ok = req_s && !lock_active && ((phase == PH_IDLE) || end_ok);

  // R5
  late_no_arm_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_T3 || phase == PH_TW) && !armed_q) |=> !armed_q);
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic handover_ok,
  output logic hold_ack,
  output logic bus_float
);
  logic ack_q;
  logic float_q;
  logic ack_next;

  assign ack_next = ack_q ? req_s : handover_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      float_q <= 1'b0;
    end else begin
      ack_q   <= ack_next;
      float_q <= ack_next | ack_q;
    end
  end

  assign hold_ack  = ack_q;
  assign bus_float = float_q;

  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !req_s) |=> !hold_ack);

  // R10
  float_tail_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |-> bus_float);
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bus_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_req,
  input  logic [PHASE_W-1:0] cycle_phase,
  input  logic               low_byte_half,
  input  logic               inta_first,
  input  logic               lock_active,
  output logic               hold_ack,
  output logic               bus_float
);
  logic       req_s;
  logic       handover_ok;
  bus_phase_e phase;

  assign phase = bus_phase_e'(cycle_phase);

  req_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .async_in(hold_req), .sync_out(req_s)
  );

  cycle_eligibility i_elig (
    .clk(clk), .rst(rst), .req_s(req_s), .phase(phase),
    .low_byte_half(low_byte_half), .inta_first(inta_first),
    .lock_active(lock_active), .handover_ok(handover_ok)
  );

  hold_ctrl i_ctrl (
    .clk(clk), .rst(rst), .req_s(req_s), .handover_ok(handover_ok),
    .hold_ack(hold_ack), .bus_float(bus_float)
  );

  // R10
  float_covers_ack_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> bus_float);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack && lock_active) |=> !hold_ack);

  // R6
  low_byte_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack && phase == PH_T4 && low_byte_half) |=> !hold_ack);

  // R7
  inta_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack && phase == PH_T4 && inta_first) |=> !hold_ack);

  // R3
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack && req_s && phase == PH_IDLE && !lock_active) |=> hold_ack);

  // R4
  mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack && phase != PH_IDLE && phase != PH_T4) |=> !hold_ack);
endmodule

// File: tb/test_bus_hold_arbiter.sv
module test_bus_hold_arbiter;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_req = 1'b0;
  logic [2:0] cycle_phase = 3'd0;
  logic       low_byte_half = 1'b0;
  logic       inta_first = 1'b0;
  logic       lock_active = 1'b0;
  logic       hold_ack;
  logic       bus_float;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // reference model state
  bit m_ack, m_float, m_seen;
  bit req_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter i_bus_hold_arbiter (
    .clk(clk), .rst(rst), .hold_req(hold_req), .cycle_phase(cycle_phase),
    .low_byte_half(low_byte_half), .inta_first(inta_first),
    .lock_active(lock_active), .hold_ack(hold_ack), .bus_float(bus_float)
  );

  always @(posedge clk) begin
    bit rs, nack;
    if (rst) begin
      m_ack = 0; m_float = 0; m_seen = 0;
      req_hist = {1'b0, 1'b0};
    end else begin
      rs = req_hist[1];
      if (m_ack) nack = rs;
      else nack = rs && !lock_active &&
                  (cycle_phase == 0 ||
                   (cycle_phase == 5 && m_seen && !low_byte_half && !inta_first));
      if (!rs || cycle_phase == 5) m_seen = 0;
      else if (cycle_phase == 1 || cycle_phase == 2) m_seen = 1;
      m_float = nack || m_ack;
      m_ack = nack;
      req_hist.push_front(hold_req);
      void'(req_hist.pop_back());
    end
  end

  task automatic check_bit(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_bit(tag, "hold_ack", hold_ack, m_ack);
    check_bit(tag, "bus_float", bus_float, m_float);
  endtask

  task automatic run_cycle(bit lowb, bit inta, int nwait);
    low_byte_half = lowb; inta_first = inta;
    cycle_phase = 1; tick();
    cycle_phase = 2; tick();
    cycle_phase = 3; tick();
    for (int w = 0; w < nwait; w++) begin cycle_phase = 4; tick(); end
    cycle_phase = 5; tick();
    cycle_phase = 0; low_byte_half = 0; inta_first = 0;
  endtask

  task automatic release_bus();
    tag = "R9";
    hold_req = 0; cycle_phase = 0;
    tick(); tick(); tick();
    check_bit("R9", "hold_ack after drop", hold_ack, 1'b0);
    check_bit("R10", "bus_float tail", bus_float, 1'b1);
    tag = "R10";
    tick();
    check_bit("R10", "bus_float off", bus_float, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    tick(); tick();
    rst = 0;
    tick();
    check_bit("R1", "hold_ack reset", hold_ack, 1'b0);
    check_bit("R1", "bus_float reset", bus_float, 1'b0);

    // idle grant through the synchronizer
    tag = "R2";
    hold_req = 1;
    tick(); tick();
    check_bit("R2", "no early ack", hold_ack, 1'b0);
    tag = "R3";
    tick();
    check_bit("R3", "idle grant", hold_ack, 1'b1);
    check_bit("R10", "float with ack", bus_float, 1'b1);
    tick();
    release_bus();
    tick(); tick();

    // request visible by T2, granted at T4
    tag = "R4";
    hold_req = 1; tick();
    low_byte_half = 0; inta_first = 0;
    cycle_phase = 1; tick();
    cycle_phase = 2; tick();
    cycle_phase = 3; tick();
    check_bit("R4", "no grant at T3", hold_ack, 1'b0);
    cycle_phase = 5; tick();
    check_bit("R4", "grant at T4", hold_ack, 1'b1);
    cycle_phase = 0; tick();
    release_bus();
    tick(); tick();

    // late request deferred to next cycle
    tag = "R5";
    cycle_phase = 1; tick();
    hold_req = 1; cycle_phase = 2; tick();
    cycle_phase = 3; tick();
    cycle_phase = 4; tick();
    cycle_phase = 5; tick();
    check_bit("R5", "late request not granted", hold_ack, 1'b0);
    run_cycle(0, 0, 2);
    check_bit("R5", "deferred grant", hold_ack, 1'b1);
    tick();
    release_bus();
    tick(); tick();

    // low-byte half blocks
    tag = "R6";
    hold_req = 1; tick();
    run_cycle(1, 0, 0);
    check_bit("R6", "low byte blocks", hold_ack, 1'b0);
    run_cycle(0, 0, 1);
    check_bit("R6", "grant after word", hold_ack, 1'b1);
    tick();
    release_bus();
    tick(); tick();

    // first acknowledge cycle blocks
    tag = "R7";
    hold_req = 1; tick();
    run_cycle(0, 1, 0);
    check_bit("R7", "inta first blocks", hold_ack, 1'b0);
    run_cycle(0, 0, 0);
    check_bit("R7", "grant after inta", hold_ack, 1'b1);
    tick();
    release_bus();
    tick(); tick();

    // lock blocks in idle and in cycles
    tag = "R8";
    lock_active = 1; hold_req = 1;
    for (int i = 0; i < 5; i++) tick();
    check_bit("R8", "lock blocks idle", hold_ack, 1'b0);
    run_cycle(0, 0, 0);
    check_bit("R8", "lock blocks T4", hold_ack, 1'b0);
    lock_active = 0; tick();
    check_bit("R8", "grant after unlock", hold_ack, 1'b1);
    tick();
    release_bus();
    tick(); tick();

    // one-clock request pulse on an idle bus
    tag = "R9";
    hold_req = 1; tick();
    hold_req = 0;
    for (int i = 0; i < 6; i++) tick();
    check_bit("R9", "pulse released", hold_ack, 1'b0);
    check_bit("R10", "pulse float off", bus_float, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule